// File: doc/BRIEF.md
# Widening Vector Multiply-Accumulate Unit

This unit performs one widening multiply-accumulate over a 128-bit vector on each valid input cycle. It takes narrow unsigned lanes from either the low or the high 64 bits of two source vectors. Each pair of lanes is multiplied into a product twice the lane width. That product is added to, or subtracted from, the matching double-width lane of a 128-bit accumulator vector.

In by-scalar mode, the second multiplicand is not taken lane by lane. Instead, one lane of the whole second source, chosen by an index, is broadcast to every product. The lane width is 8, 16 or 32 bits, which gives 8, 4 or 2 result lanes.

The result is registered. It appears one clock after the input strobe, together with a valid flag.

Top module: `vec_widen_mac`

## Requirements
- R1: Result lane i occupies bits [2·E·i +: 2·E] of `result`, where E is the narrow lane width. There are 64/E result lanes.
- R2: Narrow lane i of each source is taken from bits [H + E·i +: E], with H = 0 when `hi_half` is 0 and H = 64 when it is 1.
- R3: When `sub_en` is 1, each result lane is the accumulator lane minus the product. When it is 0, each result lane is the accumulator lane plus the product.
- R4: Operands are unsigned and each product is kept at its full 2·E bits (for example, 0xFF × 0xFF gives 0xFE01 for E = 8).
- R5: Each addition or subtraction wraps modulo 2^(2·E) and never carries or borrows into a neighbouring lane.
- R6: `esize_sel` selects E: 0 gives 8, 1 gives 16, 2 gives 32, and 3 behaves like 2.
- R7: When `by_scalar` is 1, the second multiplicand for every lane is lane (`lane_idx` mod 128/E) of the full `src_b`. In this mode the lane is counted from bit 0, with no effect from `hi_half`.
- R8: `out_valid` equals `in_valid` from one cycle earlier. `result` loads only after a cycle with `in_valid` high and holds otherwise.
- R9: A synchronous reset (`rst` high at a clock edge) clears `out_valid` and `result` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| src_a | input | 128 | First multiplicand vector |
| src_b | input | 128 | Second multiplicand vector / scalar source |
| acc_in | input | 128 | Accumulator vector of double-width lanes |
| hi_half | input | 1 | 1 selects upper 64 bits of the sources |
| sub_en | input | 1 | 1 subtracts products, 0 adds them |
| esize_sel | input | 2 | Narrow lane width code |
| by_scalar | input | 1 | Broadcast one lane of src_b |
| lane_idx | input | 4 | Broadcast lane index |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Result vector |

## Verification
The block holds only the result register and the valid flag. A wrong internal value therefore reaches the ports on the cycle right after the strobe, and it stays visible until the next strobe loads the register.

A fault in the lane slicing shows up as a wrong group of 2·E result bits. A wrong half-select, size decode or broadcast index corrupts every lane of that mode at once. A carry leaking across a lane boundary only shows when a lane wraps, so the wrap and borrow cases at all-ones and zero are driven on purpose.

// File: rtl/vec_widen_mac.sv
module vec_widen_mac #(
  parameter int VW    = 128,
  parameter int IDX_W = $clog2(VW / 8)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [VW-1:0]     src_a,
  input  logic [VW-1:0]     src_b,
  input  logic [VW-1:0]     acc_in,
  input  logic              hi_half,
  input  logic              sub_en,
  input  logic [1:0]        esize_sel,
  input  logic              by_scalar,
  input  logic [IDX_W-1:0]  lane_idx,
  output logic              out_valid,
  output logic [VW-1:0]     result
);
  localparam int HW = VW / 2;

  logic [HW-1:0] a_half, b_half;
  assign a_half = hi_half ? src_a[VW-1:HW] : src_a[HW-1:0];
  assign b_half = hi_half ? src_b[VW-1:HW] : src_b[HW-1:0];

  logic [2:0][VW-1:0] lane_res;

  for (genvar g = 0; g < 3; g++) begin : g_size
    localparam int ES = 8 << g;
    localparam int NL = HW / ES;
    localparam int NB = VW / ES;
    localparam int LW = $clog2(NB);

    logic [LW-1:0] sidx;
    logic [ES-1:0] scal;
    assign sidx = lane_idx[LW-1:0];
    assign scal = src_b[ES*sidx +: ES];

    for (genvar l = 0; l < NL; l++) begin : g_lane
      logic [ES-1:0]   x, y;
      logic [2*ES-1:0] p, acc_l;
      assign x     = a_half[l*ES +: ES];
      assign y     = by_scalar ? scal : b_half[l*ES +: ES];
      assign p     = {{ES{1'b0}}, x} * {{ES{1'b0}}, y};
      assign acc_l = acc_in[l*2*ES +: 2*ES];
      assign lane_res[g][l*2*ES +: 2*ES] = sub_en ? acc_l - p : acc_l + p;
    end
  end

  logic [VW-1:0] res_d;
  always_comb begin
    case (esize_sel)
      2'd0:    res_d = lane_res[0];
      2'd1:    res_d = lane_res[1];
      default: res_d = lane_res[2];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= res_d;
    end
  end

  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  assert_reset_clears_R9: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0));

  assert_valid_latency_R8: assert property (@(posedge clk) disable iff (rst)
    armed |-> out_valid == $past(in_valid));

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(in_valid)) |-> $stable(result));

  assert_wide_add_lane0_R4: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(in_valid && esize_sel == 2'd2 && !by_scalar && !sub_en && !hi_half))
    |-> result[63:0] == $past(acc_in[63:0]) + 64'($past(src_a[31:0])) * 64'($past(src_b[31:0])));

  assert_sub_lane0_R3: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(in_valid && esize_sel == 2'd1 && !by_scalar && sub_en && !hi_half))
    |-> result[31:0] == $past(acc_in[31:0]) - 32'($past(src_a[15:0])) * 32'($past(src_b[15:0])));
endmodule

// File: tb/vec_widen_mac_tb.sv
`timescale 1ns/1ps
module vec_widen_mac_tb;
  logic clk = 0, rst = 1, in_valid = 0, hi_half = 0, sub_en = 0, by_scalar = 0;
  logic [127:0] src_a = '0, src_b = '0, acc_in = '0;
  logic [1:0] esize_sel = 0;
  logic [3:0] lane_idx = 0;
  logic out_valid;
  logic [127:0] result;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vec_widen_mac u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .acc_in(acc_in), .hi_half(hi_half), .sub_en(sub_en), .esize_sel(esize_sel),
    .by_scalar(by_scalar), .lane_idx(lane_idx), .out_valid(out_valid), .result(result)
  );

  // ctl = {hi, sub, scalar, size[1:0], idx[3:0]}
  localparam int N = 11;
  localparam logic [127:0] TA [N] = '{
    128'h89AB_CDEF_0123_4567_FFFF_FFFF_0000_0003,
    128'hDEAD_BEEF_1234_5678_0000_0001_0000_0002,
    128'h0000_0005_0000_0007_8000_0000_FFFF_FFFF,
    128'hFFFF_0001_7FFF_8000_1111_2222_3333_4444,
    128'h0102_0304_0506_0708_FF80_7F01_10FE_02FF,
    128'hFFFE_FDFC_0A0B_0C0D_1111_1111_1111_1111,
    128'h0000_0000_0000_0000_0000_0009_0000_000A,
    128'hABCD_1234_0002_0003_5555_6666_7777_8888,
    128'h0000_0000_0000_0000_F0E1_D2C3_B4A5_9687,
    128'h0000_0000_0000_0000_0000_0100_FFFF_FFFF,
    128'h0000_0004_0000_0006_0000_0000_0000_0000};
  localparam logic [127:0] TB [N] = '{
    128'h0000_0000_0000_0000_FFFF_FFFF_0000_0005,
    128'hCAFE_F00D_0000_0010_0000_0000_0000_0000,
    128'h0000_0000_0000_0000_0000_0002_0000_0003,
    128'hFFFF_FFFF_0002_0003_0000_0000_0000_0000,
    128'h0000_0000_0000_0000_FF02_0203_FF10_FFFF,
    128'h0102_0304_FF01_0203_0000_0000_0000_0000,
    128'h0000_0007_0000_0000_0000_0000_0000_0000,
    128'h0000_0000_000A_0000_0000_0000_0000_0000,
    128'h03FF_0000_0000_0000_0000_0000_0000_0000,
    128'h0000_0000_0000_0000_0000_0010_FFFF_FFFF,
    128'h0000_0000_0000_0064_0000_0000_0000_0000};
  localparam logic [127:0] TC [N] = '{
    128'h0000_0000_0000_0001_FFFF_FFFF_FFFF_FFFF,
    128'h1000_0000_0000_0000_0000_0000_0000_0001,
    128'h0000_0000_0000_0000_0000_0000_0000_0010,
    128'h0000_0001_0000_0000_0000_0005_FFFF_FFFF,
    128'hFFFF_0000_1234_8000_0001_FFFF_0000_ABCD,
    128'h0000_0001_0002_0003_0004_0005_0006_0007,
    128'h0000_0000_0000_0100_0000_0000_0000_0030,
    128'hFFFF_FFFF_0000_0001_0000_0000_0000_0000,
    128'h0000_0001_0002_0003_0004_0005_0006_0007,
    128'h0000_0000_0000_0001_0000_0000_0000_0000,
    128'hFFFF_FFFF_FFFF_FFFF_0000_0000_0000_0000};
  localparam logic [8:0] TCTL [N] = '{
    9'b0_0_0_10_0000, 9'b1_0_0_10_0000, 9'b0_1_0_10_0000, 9'b1_1_0_01_0000,
    9'b0_0_0_00_0000, 9'b1_0_0_00_0000, 9'b0_1_1_10_0011, 9'b1_0_1_01_0110,
    9'b0_0_1_00_1111, 9'b0_0_0_11_0000, 9'b1_0_1_10_1110};

  function automatic logic [127:0] model(input logic [127:0] a, b, c, input logic [8:0] ctl);
    int es, base;
    logic [127:0] r;
    logic [63:0] x, y, p, accl, m1, m2;
    case (ctl[5:4])
      2'd0: es = 8;
      2'd1: es = 16;
      default: es = 32;
    endcase
    m1 = (64'd1 << es) - 64'd1;
    m2 = (es == 32) ? '1 : (64'd1 << (2 * es)) - 64'd1;
    base = ctl[8] ? 64 : 0;
    r = '0;
    for (int i = 0; i < 64 / es; i++) begin
      x = 64'(a >> (base + es * i)) & m1;
      if (ctl[6]) y = 64'(b >> (es * (int'(ctl[3:0]) % (128 / es)))) & m1;
      else        y = 64'(b >> (base + es * i)) & m1;
      p = x * y;
      accl = 64'(c >> (2 * es * i)) & m2;
      accl = ctl[7] ? accl - p : accl + p;
      r = r | (128'(accl & m2) << (2 * es * i));
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [127:0] a, b, c, input logic [8:0] ctl);
    @(negedge clk);
    src_a = a; src_b = b; acc_in = c;
    {hi_half, sub_en, by_scalar, esize_sel, lane_idx} = ctl;
    in_valid = 1;
    @(negedge clk);
    in_valid = 0;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [127:0] held;
    repeat (3) @(negedge clk);
    check("R9 reset out_valid", {127'd0, out_valid}, 128'd0);
    check("R9 reset result", result, 128'd0);
    rst = 0;

    for (int k = 0; k < N; k++) begin
      issue(TA[k], TB[k], TC[k], TCTL[k]);
      check($sformatf("R8 valid entry %0d", k), {127'd0, out_valid}, 128'd1);
      check($sformatf("R1 R2 R3 R6 R7 entry %0d", k), result,
            model(TA[k], TB[k], TC[k], TCTL[k]));
    end

    held = result;
    @(negedge clk);
    check("R8 out_valid drops", {127'd0, out_valid}, 128'd0);
    src_a = '1; src_b = '1; acc_in = '1;
    repeat (2) @(negedge clk);
    check("R8 result held", result, held);

    issue(128'h0, 128'h0, 128'hFF, 9'b0_0_0_00_0000);
    src_a = 128'hFF; src_b = 128'hFF; acc_in = '0;
    issue(128'hFF, 128'hFF, 128'h0, 9'b0_0_0_00_0000);
    check("R4 full product", result, 128'h0000_0000_0000_0000_0000_0000_0000_FE01);

    issue(128'h1, 128'h1, 128'h0, 9'b0_1_0_10_0000);
    check("R5 borrow wrap", result, 128'h0000_0000_0000_0000_FFFF_FFFF_FFFF_FFFF);

    issue(128'h0000_0000_0000_0000_0000_0000_0000_0001, 128'h1,
          128'h0000_0000_0000_0000_FFFF_FFFF_FFFF_FFFF, 9'b0_0_0_10_0000);
    check("R5 no carry across lanes", result, 128'h0);

    issue(128'h0000_0000_0000_0000_0003_0002_0001_0004,
          128'h0000_0000_0000_0000_0000_0000_0000_0000, 128'h0, 9'b0_0_1_01_0000);
    check("R7 scalar zero lane", result, 128'h0);

    @(negedge clk);
    src_a = 128'h5; src_b = 128'h5; acc_in = '0;
    {hi_half, sub_en, by_scalar, esize_sel, lane_idx} = 9'b0_0_0_10_0000;
    in_valid = 1; rst = 1;
    @(negedge clk);
    in_valid = 0; rst = 0;
    check("R9 reset beats valid flag", {127'd0, out_valid}, 128'd0);
    check("R9 reset clears result", result, 128'd0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule